// File: doc/BRIEF.md
# Dual-Clock FIFO with Combined Flags

This block is a first-in first-out buffer that sits on a fixed 4096-bit storage array. The word width is picked from 1, 2, 4 or 8 bits, and the depth follows as 4096 divided by the width. Writes are taken on the write clock and reads on the read clock. The two clocks may be one net or fully unrelated. Each side has its own enable. The block keeps its own pointers. Each pointer crosses into the other clock domain in Gray code through a two-flop synchronizer.

Occupancy is measured in the read clock domain, and three status outputs come from it. One flag is raised when the buffer is either empty or full, and a companion bit tells which of the two holds. A second flag shows the buffer at least half full. A third flag warns that the buffer is near either end, measured against a programmable threshold. Parameters select an optional output register on the read data and an inverted clock on either port.

Top module: `dcfifo_flags`

## Requirements
- R1: The parameter WIDTH takes the values 1, 2, 4 or 8, and the depth is 4096/WIDTH words. With the default WIDTH=8 the buffer reports full after exactly 512 accepted writes.
- R2: A write stores wr_data_i on a rising write-clock edge where wr_en_i=1 and the buffer is not full. A read pops the oldest word on a rising read-clock edge where rd_en_i=1 and the buffer is not empty. With OUT_REG=0 the popped word is on rd_data_o after that edge; OUT_REG=1 adds one read-clock cycle.
- R3: ef_o=1 when the read-side occupancy is 0 or DEPTH. ef_full_o=1 only when the occupancy is DEPTH, so ef_o=1 with ef_full_o=0 means empty.
- R4: hf_o=1 when the read-side occupancy is at least DEPTH/2.
- R5: almost_o=1 when the read-side occupancy is at most thresh_i or at least DEPTH-thresh_i.
- R6: A write attempted while the buffer is full is dropped. It changes neither the stored contents nor the occupancy.
- R7: A read attempted while the buffer is empty is dropped. rd_data_o keeps its value and the flags stay at empty.
- R8: A read changes the flags on the same read-clock edge that pops the word. A write reaches the flags on the second rising read-clock edge after the write edge, when both clocks are aligned.
- R9: While rst_ni=0 and after reset: ef_o=1, ef_full_o=0, hf_o=0, almost_o=1 and rd_data_o=0.
- R10: With unrelated clock frequencies, every word written is read back once, in order, with no loss. Each Gray-coded pointer changes by at most one bit per edge of its clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Write-side clock |
| rd_clk_i | input | 1 | Read-side clock |
| rst_ni | input | 1 | Asynchronous reset for both domains, active low |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | WIDTH | Word to store |
| rd_en_i | input | 1 | Read request |
| thresh_i | input | log2(DEPTH) | Threshold for the almost-empty/almost-full flag |
| rd_data_o | output | WIDTH | Word read out |
| ef_o | output | 1 | Empty-or-full flag |
| ef_full_o | output | 1 | Set when ef_o means full |
| hf_o | output | 1 | Half-full flag |
| almost_o | output | 1 | Near-empty or near-full flag |

## Verification
The bench fills the buffer one word at a time up to full and checks all four flag outputs at every occupancy, then drains it the same way. A wrong boundary in the half-full or almost comparison would show up as a flag that changes one word early or late. The bench also writes into a full buffer and reads from an empty one. A design that let either pointer move in those cases would show a stray word later in the drain, or would flip the flags into the full state when the buffer is empty. It measures the exact read-clock cycle in which a single write clears the empty flag. It then streams words under unrelated clock periods, where a broken pointer synchronizer would drop or repeat words.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  localparam int TOTAL_BITS = 4096;
  localparam int PTR_MAX    = 13;

  function automatic logic [PTR_MAX-1:0] bin2gray(input logic [PTR_MAX-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_MAX-1:0] gray2bin(input logic [PTR_MAX-1:0] g);
    logic [PTR_MAX-1:0] b;
    b[PTR_MAX-1] = g[PTR_MAX-1];
    for (int i = PTR_MAX-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/dcfifo_ram.sv
module dcfifo_ram #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             wclk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             re_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/dcfifo_wr_ctl.sv
module dcfifo_wr_ctl
  import dcfifo_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [PW-1:0] rgray_s_i,
  output logic [PW-1:0] wbin_o,
  output logic [PW-1:0] wgray_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic          full_o
);
  logic [PW-1:0] rbin_s, wbin_n;

  assign rbin_s  = PW'(gray2bin(PTR_MAX'(rgray_s_i)));
  assign full_o  = (wbin_o - rbin_s) == PW'(DEPTH);
  assign we_o    = wr_en_i && !full_o;
  assign waddr_o = wbin_o[AW-1:0];
  assign wbin_n  = wbin_o + PW'(we_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_o  <= '0;
      wgray_o <= '0;
    end else begin
      wbin_o  <= wbin_n;
      wgray_o <= PW'(bin2gray(PTR_MAX'(wbin_n)));
    end
  end
endmodule

// File: rtl/dcfifo_rd_ctl.sv
module dcfifo_rd_ctl
  import dcfifo_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [AW-1:0] thresh_i,
  input  logic [PW-1:0] wgray_s_i,
  output logic [PW-1:0] rbin_o,
  output logic [PW-1:0] rgray_o,
  output logic          re_o,
  output logic [AW-1:0] raddr_o,
  output logic          empty_o,
  output logic          ef_o,
  output logic          ef_full_o,
  output logic          hf_o,
  output logic          almost_o
);
  logic [PW-1:0] wbin_s, rbin_n, occ, thr;

  assign wbin_s  = PW'(gray2bin(PTR_MAX'(wgray_s_i)));
  assign occ     = wbin_s - rbin_o;
  assign thr     = PW'(thresh_i);
  assign empty_o = occ == '0;
  assign re_o    = rd_en_i && !empty_o;
  assign raddr_o = rbin_o[AW-1:0];
  assign rbin_n  = rbin_o + PW'(re_o);

  // flags all judged from read-side view of occupancy
  assign ef_full_o = occ == PW'(DEPTH);
  assign ef_o      = empty_o || ef_full_o;
  assign hf_o      = occ >= PW'(DEPTH / 2);
  assign almost_o  = (occ <= thr) || (occ >= PW'(DEPTH) - thr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_o  <= '0;
      rgray_o <= '0;
    end else begin
      rbin_o  <= rbin_n;
      rgray_o <= PW'(bin2gray(PTR_MAX'(rbin_n)));
    end
  end
endmodule

// File: rtl/dcfifo_flags.sv
module dcfifo_flags #(
  parameter int WIDTH      = 8,
  parameter bit OUT_REG    = 1'b0,
  parameter bit WR_CLK_INV = 1'b0,
  parameter bit RD_CLK_INV = 1'b0,
  localparam int DEPTH     = dcfifo_pkg::TOTAL_BITS / WIDTH,
  localparam int AW        = $clog2(DEPTH),
  localparam int PW        = AW + 1
) (
  input  logic             wr_clk_i,
  input  logic             rd_clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    thresh_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             ef_o,
  output logic             ef_full_o,
  output logic             hf_o,
  output logic             almost_o
);
  logic wclk, rclk;
  logic [PW-1:0] wr_ptr, wr_gray, rd_ptr, rd_gray, wgray_s, rgray_s;
  logic we, re, wr_full, rd_empty;
  logic [AW-1:0] waddr, raddr;
  logic [WIDTH-1:0] ram_q;

  if (WR_CLK_INV) begin : g_winv
    assign wclk = ~wr_clk_i;
  end else begin : g_wtrue
    assign wclk = wr_clk_i;
  end

  if (RD_CLK_INV) begin : g_rinv
    assign rclk = ~rd_clk_i;
  end else begin : g_rtrue
    assign rclk = rd_clk_i;
  end

  dcfifo_wr_ctl #(.DEPTH(DEPTH)) u_wr (
    .clk_i(wclk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rgray_s_i(rgray_s),
    .wbin_o(wr_ptr), .wgray_o(wr_gray), .we_o(we), .waddr_o(waddr), .full_o(wr_full)
  );

  dcfifo_rd_ctl #(.DEPTH(DEPTH)) u_rd (
    .clk_i(rclk), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .thresh_i(thresh_i),
    .wgray_s_i(wgray_s), .rbin_o(rd_ptr), .rgray_o(rd_gray), .re_o(re),
    .raddr_o(raddr), .empty_o(rd_empty), .ef_o(ef_o), .ef_full_o(ef_full_o),
    .hf_o(hf_o), .almost_o(almost_o)
  );

  dcfifo_sync #(.W(PW)) u_w2r (.clk_i(rclk), .rst_ni(rst_ni), .d_i(wr_gray), .q_o(wgray_s));
  dcfifo_sync #(.W(PW)) u_r2w (.clk_i(wclk), .rst_ni(rst_ni), .d_i(rd_gray), .q_o(rgray_s));

  dcfifo_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
    .wclk_i(wclk), .we_i(we), .waddr_i(waddr), .wdata_i(wr_data_i),
    .rclk_i(rclk), .rst_ni(rst_ni), .re_i(re), .raddr_i(raddr), .rdata_o(ram_q)
  );

  if (OUT_REG) begin : g_oreg
    always_ff @(posedge rclk or negedge rst_ni) begin
      if (!rst_ni) rd_data_o <= '0;
      else         rd_data_o <= ram_q;
    end
  end else begin : g_ocomb
    assign rd_data_o = ram_q;
  end
endmodule

// File: rtl/dcfifo_flags_chk.sv
module dcfifo_flags_chk #(
  parameter int PW = 10
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic          wr_full,
  input logic          rd_empty,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr,
  input logic [PW-1:0] wr_gray,
  input logic [PW-1:0] rd_gray,
  input logic          ef_o,
  input logic          ef_full_o,
  input logic          hf_o,
  input logic          almost_o
);
  // R6
  full_write_drop_chk: assert property (@(posedge wclk) disable iff (!rst_ni)
    (wr_full && wr_en_i) |=> $stable(wr_ptr));

  // R7
  empty_read_drop_chk: assert property (@(posedge rclk) disable iff (!rst_ni)
    (rd_empty && rd_en_i) |=> $stable(rd_ptr));

  // R3
  full_dir_chk: assert property (@(posedge rclk) disable iff (!rst_ni)
    ef_full_o |-> ef_o);

  // R4
  full_implies_levels_chk: assert property (@(posedge rclk) disable iff (!rst_ni)
    ef_full_o |-> (hf_o && almost_o));

  // R10
  wgray_step_chk: assert property (@(posedge wclk) disable iff (!rst_ni)
    $onehot0(wr_gray ^ $past(wr_gray)));

  // R10
  rgray_step_chk: assert property (@(posedge rclk) disable iff (!rst_ni)
    $onehot0(rd_gray ^ $past(rd_gray)));
endmodule

bind dcfifo_flags dcfifo_flags_chk #(.PW(PW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .wr_full(wr_full), .rd_empty(rd_empty), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
  .wr_gray(wr_gray), .rd_gray(rd_gray), .ef_o(ef_o), .ef_full_o(ef_full_o),
  .hf_o(hf_o), .almost_o(almost_o)
);

// File: tb/dcfifo_flags_test.sv
module dcfifo_flags_test;
  localparam int WIDTH = 8;
  localparam int DEPTH = 4096 / WIDTH;
  localparam int AW    = $clog2(DEPTH);
  localparam int THR   = 16;

  logic wclk = 1'b0, rclk = 1'b0, rst_ni = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [WIDTH-1:0] wr_data = '0;
  logic [AW-1:0] thresh = AW'(THR);
  logic [WIDTH-1:0] rd_data;
  logic ef, ef_full, hf, almost;
  int rhalf = 10;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 wclk = ~wclk;
  always #(rhalf) rclk = ~rclk;

  dcfifo_flags #(.WIDTH(WIDTH)) uut (
    .wr_clk_i(wclk), .rd_clk_i(rclk), .rst_ni(rst_ni), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .thresh_i(thresh), .rd_data_o(rd_data),
    .ef_o(ef), .ef_full_o(ef_full), .hf_o(hf), .almost_o(almost)
  );

  function automatic logic [WIDTH-1:0] pat(input int i);
    return WIDTH'(i * 37 + 5);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_flags(input int occ);
    check("R3", "ef", int'(ef), int'(occ == 0 || occ == DEPTH));
    check("R3", "ef_full", int'(ef_full), int'(occ == DEPTH));
    check("R4", "hf", int'(hf), int'(occ >= DEPTH / 2));
    check("R5", "almost", int'(almost), int'(occ <= THR || occ >= DEPTH - THR));
  endtask

  task automatic wr1(input logic [WIDTH-1:0] d);
    @(negedge wclk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic rd1(output logic [WIDTH-1:0] v);
    @(negedge rclk);
    rd_en = 1'b1;
    @(negedge rclk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  initial begin
    logic [WIDTH-1:0] v;
    repeat (3) @(negedge rclk);
    // R9 during reset
    check("R9", "rd_data in reset", int'(rd_data), 0);
    chk_flags(0);
    rst_ni = 1'b1;
    repeat (2) @(negedge rclk);
    check("R9", "rd_data after reset", int'(rd_data), 0);
    chk_flags(0);

    // R1 R3 R4 R5 fill sweep
    for (int i = 0; i < DEPTH; i++) begin
      wr1(pat(i));
      repeat (3) @(negedge rclk);
      chk_flags(i + 1);
    end
    check("R1", "full at depth", int'(ef_full), 1);

    // R6 write into full buffer
    wr1(8'hEE);
    repeat (4) @(negedge rclk);
    chk_flags(DEPTH);

    // R2 drain sweep, flags follow each read at once (R8)
    for (int i = 0; i < DEPTH; i++) begin
      rd1(v);
      check("R2", "drain data", int'(v), int'(pat(i)));
      chk_flags(DEPTH - 1 - i);
    end

    // R7 read from empty buffer
    rd1(v);
    check("R7", "data held", int'(v), int'(pat(DEPTH - 1)));
    chk_flags(0);

    // R8 write-to-flag latency
    wr1(8'h5A);
    check("R8", "ef half cycle after write", int'(ef), 1);
    @(negedge rclk);
    check("R8", "ef one cycle later", int'(ef), 1);
    @(negedge rclk);
    check("R8", "ef cleared after two edges", int'(ef), 0);
    rd1(v);
    check("R8", "single word", int'(v), 8'h5A);
    check("R8", "ef after read", int'(ef), 1);
    check("R8", "ef_full after read", int'(ef_full), 0);

    // R10 unrelated clocks, concurrent stream
    rhalf = 17;
    fork
      begin
        for (int i = 0; i < 300; i++) begin
          @(negedge wclk);
          wr_en = 1'b1;
          wr_data = pat(i + 1000);
        end
        @(negedge wclk);
        wr_en = 1'b0;
      end
      begin
        int got = 0;
        bit pend = 1'b0;
        while (got < 300) begin
          @(negedge rclk);
          if (pend) begin
            check("R10", "stream data", int'(rd_data), int'(pat(got + 1000)));
            got++;
          end
          pend = (ef && !ef_full) ? 1'b0 : (got < 300);
          rd_en = pend;
        end
        rd_en = 1'b0;
      end
    join
    repeat (6) @(negedge rclk);
    chk_flags(0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #3000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule